// File: doc/BRIEF.md
# Shadowed Compare Latch Controller

This block is the compare stage of a multi-channel timer. Software writes a new compare value into a per-channel holding register. The comparison against the counter never reads that holding register directly. It reads a shadow latch instead, and this controller decides on which clock edge each shadow latch takes its holding register's value. A write made in the middle of a period therefore cannot disturb the waveform of that period. The exception is a channel that is set to take new values at once.

Each channel carries a 2-bit load-policy code. The four policies are:
- take the value at once;
- take it when the counter reaches zero;
- take it at the turning points of up/down counting;
- take it when the counter reaches the period value.

A global 2-bit grouping code can bind channels together so that they change in the same cycle. A global 2-bit length code shortens the active counter width. The counter, its direction and the period value come from outside the block. The block returns the active latch values and one compare-equal strobe per channel.

Top module: `cmp_shadow_ctrl`

## Requirements
- R1: After reset every holding register and shadow latch is zero and no channel is marked as written, so with the counter at zero every compare-equal strobe is high.
- R2: The length code selects the active width: code 0 uses all CW bits, code 1 uses CW-4, code 2 uses CW-6 and code 3 uses CW-8. Counter, period and latch values are masked to the active bits before any comparison or event test, and the latch output shows only the active bits.
- R3: Policy code 0 (immediate): the shadow latch takes the written value on the same clock edge as the write, and the new value is visible on the latch output from the next cycle.
- R4: Policy code 1: a written value is copied to the latch on the first clock edge at which the masked counter equals zero.
- R5: Policy code 2: the copy happens at an edge where the masked counter equals the masked period while counting up (cnt_down=0), or where it equals zero while counting down (cnt_down=1). It does not happen at either point in the other direction.
- R6: Policy code 3: the copy happens at an edge where the masked counter equals the masked period, independent of direction.
- R7: While no copy is made, a write changes neither the latch output nor the compare-equal strobe.
- R8: Grouping code 0 keeps every channel separate. Code 1 pairs channels {0,1}, {2,3} and {4,5}. Code 2 forms {0,1,2} and {3,4,5}. Code 3 binds all channels. The policy code of the lowest-numbered member governs the whole group, and all members copy on the same edge.
- R9: A group copies only once every member has been written since its last copy. Until then nothing in the group changes, and a member written twice contributes its latest value.
- R10: cmp_eq[i] is high in the same cycle that the masked counter equals the masked latch value of channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_sel | input | 2 | Active counter length code |
| grp_sel | input | 2 | Channel grouping code |
| src_sel | input | 2*NCH | Load-policy code per channel, channel i at bits [2i+1:2i] |
| wr_en | input | 1 | Holding register write strobe |
| wr_ch | input | $clog2(NCH) | Channel addressed by the write |
| wr_data | input | CW | Value written |
| cnt | input | CW | Current counter value |
| cnt_down | input | 1 | High when the counter is counting down |
| period | input | CW | Period value of the counter |
| latch_val | output | NCH*CW | Masked shadow latch values, channel i at bits [i*CW +: CW] |
| cmp_eq | output | NCH | Compare-equal strobe per channel |

## Verification
The bench checks first that a write before the load event leaves both the latch and its strobe untouched. A design that bypassed the shadow latch would show the new value early and raise a strobe in mid-period. Turning-point loads are tried at the period while counting down and at zero while counting up; a design that ignored the direction would copy at one of these points. Group tests write only some members, rewrite one member, and give one non-leader an immediate policy code. A design that loaded on partial writes, kept a stale value, or honoured a non-leader's policy would show a wrong latch there. Masking is checked by reading one stored value under all four lengths and by a zero event that exists only in the masked counter.

// File: rtl/cmpsh_pkg.sv
package cmpsh_pkg;

   typedef enum logic [1:0] {
      LEN_FULL = 2'd0,
      LEN_M4   = 2'd1,
      LEN_M6   = 2'd2,
      LEN_M8   = 2'd3
   } len_e;

   typedef enum logic [1:0] {
      LD_IMM    = 2'd0,
      LD_ZERO   = 2'd1,
      LD_TURN   = 2'd2,
      LD_PERIOD = 2'd3
   } ldsrc_e;

   typedef enum logic [1:0] {
      GRP_NONE   = 2'd0,
      GRP_PAIRS  = 2'd1,
      GRP_HALVES = 2'd2,
      GRP_ALL    = 2'd3
   } grp_e;

   // Lowest-numbered channel of the group that contains channel ch
   function automatic int unsigned grp_leader(input int unsigned ch,
                                              input int unsigned nch,
                                              input logic [1:0]  g);
      case (grp_e'(g))
         GRP_NONE:   return ch;
         GRP_PAIRS:  return ch - (ch % 2);
         GRP_HALVES: return (ch / (nch / 2)) * (nch / 2);
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/cmpsh_event.sv
module cmpsh_event
   import cmpsh_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [1:0]    len_sel,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] period,
   input  logic          cnt_down,
   output logic [CW-1:0] mask,
   output logic [CW-1:0] cnt_m,
   output logic [3:0]    evt
);

   logic zero_hit;
   logic per_hit;

   always_comb begin
      case (len_e'(len_sel))
         LEN_FULL: mask = {CW{1'b1}};
         LEN_M4:   mask = {CW{1'b1}} >> 4;
         LEN_M6:   mask = {CW{1'b1}} >> 6;
         default:  mask = {CW{1'b1}} >> 8;
      endcase
      cnt_m    = cnt & mask;
      zero_hit = (cnt_m == '0);
      per_hit  = (cnt_m == (period & mask));
      // evt is indexed by the load-policy code
      evt[LD_IMM]    = 1'b1;
      evt[LD_ZERO]   = zero_hit;
      evt[LD_TURN]   = (per_hit & ~cnt_down) | (zero_hit & cnt_down);
      evt[LD_PERIOD] = per_hit;
   end

endmodule

// File: rtl/cmpsh_group.sv
module cmpsh_group
   import cmpsh_pkg::*;
#(
   parameter int NCH = 6
) (
   input  logic [1:0]       grp_sel,
   input  logic [2*NCH-1:0] src_sel,
   input  logic [NCH-1:0]   pend_nx,
   input  logic [3:0]       evt,
   output logic [NCH-1:0]   load
);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      int unsigned lead;
      logic        all_set;
      logic [1:0]  src;
      logic        ld;

      always_comb begin
         lead    = grp_leader(i, NCH, grp_sel);
         all_set = 1'b1;
         for (int j = 0; j < NCH; j++) begin
            if (grp_leader(j, NCH, grp_sel) == lead) all_set &= pend_nx[j];
         end
         src = src_sel[2*lead +: 2];
         ld  = all_set & evt[src];
      end

      assign load[i] = ld;
   end

endmodule

// File: rtl/cmpsh_channel.sv
module cmpsh_channel #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [CW-1:0] wr_data,
   input  logic          load,
   input  logic [CW-1:0] mask,
   input  logic [CW-1:0] cnt_m,
   output logic          pend_nx,
   output logic [CW-1:0] latch_m,
   output logic          eq
);

   logic [CW-1:0] hold_q;
   logic [CW-1:0] hold_nx;
   logic [CW-1:0] latch_q;
   logic          pend_q;

   assign pend_nx = pend_q | wr_hit;
   assign hold_nx = wr_hit ? wr_data : hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         latch_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         hold_q <= hold_nx;
         if (load) begin
            latch_q <= hold_nx;
            pend_q  <= 1'b0;
         end else begin
            pend_q <= pend_nx;
         end
      end
   end

   assign latch_m = latch_q & mask;
   assign eq      = (latch_m == cnt_m);

   // R7: no copy requested, latch keeps its value
   assert_hold_without_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(latch_q));

   // R9: a copy consumes the written mark
   assert_pend_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !pend_q);

endmodule

// File: rtl/cmp_shadow_ctrl.sv
module cmp_shadow_ctrl
   import cmpsh_pkg::*;
#(
   parameter int NCH = 6,
   parameter int CW  = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        len_sel,
   input  logic [1:0]        grp_sel,
   input  logic [2*NCH-1:0]  src_sel,
   input  logic              wr_en,
   input  logic [CHW-1:0]    wr_ch,
   input  logic [CW-1:0]     wr_data,
   input  logic [CW-1:0]     cnt,
   input  logic              cnt_down,
   input  logic [CW-1:0]     period,
   output logic [NCH*CW-1:0] latch_val,
   output logic [NCH-1:0]    cmp_eq
);

   if (NCH < 2 || (NCH % 2) != 0) begin : g_bad_nch
      $error("cmp_shadow_ctrl: NCH must be even and at least 2");
   end
   if (CW <= 8) begin : g_bad_cw
      $error("cmp_shadow_ctrl: CW must exceed 8");
   end

   logic [CW-1:0]  mask;
   logic [CW-1:0]  cnt_m;
   logic [3:0]     evt;
   logic [NCH-1:0] pend_nx;
   logic [NCH-1:0] load_w;

   cmpsh_event #(.CW(CW)) u_event (
      .len_sel  (len_sel),
      .cnt      (cnt),
      .period   (period),
      .cnt_down (cnt_down),
      .mask     (mask),
      .cnt_m    (cnt_m),
      .evt      (evt)
   );

   cmpsh_group #(.NCH(NCH)) u_group (
      .grp_sel (grp_sel),
      .src_sel (src_sel),
      .pend_nx (pend_nx),
      .evt     (evt),
      .load    (load_w)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      cmpsh_channel #(.CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_en && (wr_ch == CHW'(i))),
         .wr_data (wr_data),
         .load    (load_w[i]),
         .mask    (mask),
         .cnt_m   (cnt_m),
         .pend_nx (pend_nx[i]),
         .latch_m (latch_val[i*CW +: CW]),
         .eq      (cmp_eq[i])
      );
   end

   // R8: with every channel bound, all copy together or none do
   assert_group_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == GRP_ALL) |-> (load_w == '0 || load_w == '1));

   // R4: an ungrouped zero-policy channel copies only at masked zero
   assert_zero_policy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == GRP_NONE && src_sel[1:0] == LD_ZERO && load_w[0]) |-> (cnt_m == '0));

endmodule

// File: tb/cmp_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_shadow_ctrl_bench;

   localparam int NCH = 6;
   localparam int CW  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        len_sel = 2'd0;
   logic [1:0]        grp_sel = 2'd0;
   logic [2*NCH-1:0]  src_sel = '0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_ch = '0;
   logic [CW-1:0]     wr_data = '0;
   logic [CW-1:0]     cnt = '0;
   logic              cnt_down = 1'b0;
   logic [CW-1:0]     period = '0;
   logic [NCH*CW-1:0] latch_val;
   logic [NCH-1:0]    cmp_eq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cmp_shadow_ctrl #(.NCH(NCH), .CW(CW)) u_cmp_shadow_ctrl (
      .clk (clk), .rst_n (rst_n), .len_sel (len_sel), .grp_sel (grp_sel),
      .src_sel (src_sel), .wr_en (wr_en), .wr_ch (wr_ch), .wr_data (wr_data),
      .cnt (cnt), .cnt_down (cnt_down), .period (period),
      .latch_val (latch_val), .cmp_eq (cmp_eq)
   );

   function automatic logic [CW-1:0] lat(input int ch);
      return latch_val[ch*CW +: CW];
   endfunction

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input int ch, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_src(input int ch, input logic [1:0] code);
      src_sel[2*ch +: 2] = code;
   endtask

   task automatic t_reset();
      for (int i = 0; i < NCH; i++) chk("R1 latch after reset", lat(i), 16'h0000);
      chk("R1 strobes at counter zero", {10'd0, cmp_eq}, 16'h003F);
   endtask

   task automatic t_immediate();
      cnt = 16'h0030;
      wr(2, 16'h1234);
      chk("R3 immediate copy", lat(2), 16'h1234);
      cnt = 16'h1234; #1;
      chk("R10 strobe on match", {10'd0, cmp_eq}, 16'h0004);
   endtask

   task automatic t_zero();
      set_src(1, 2'd1);
      cnt = 16'h0055;
      wr(1, 16'h0055);
      chk("R7 latch held before zero", lat(1), 16'h0000);
      chk("R7 no strobe from held write", {15'd0, cmp_eq[1]}, 16'h0000);
      cnt = 16'h0000; step();
      chk("R4 copy at zero", lat(1), 16'h0055);
   endtask

   task automatic t_period();
      set_src(3, 2'd3);
      period = 16'h0100; cnt = 16'h0050;
      wr(3, 16'h0077);
      chk("R6 held before period", lat(3), 16'h0000);
      cnt = 16'h0100; step();
      chk("R6 copy at period", lat(3), 16'h0077);
   endtask

   task automatic t_turn();
      set_src(4, 2'd2);
      cnt = 16'h0020; cnt_down = 1'b0;
      wr(4, 16'h00A0);
      cnt = 16'h0100; cnt_down = 1'b1; step();
      chk("R5 no copy at period counting down", lat(4), 16'h0000);
      cnt = 16'h0000; cnt_down = 1'b0; step();
      chk("R5 no copy at zero counting up", lat(4), 16'h0000);
      cnt = 16'h0100; cnt_down = 1'b0; step();
      chk("R5 copy at period counting up", lat(4), 16'h00A0);
      cnt = 16'h0030;
      wr(4, 16'h00B0);
      chk("R5 held between turns", lat(4), 16'h00A0);
      cnt = 16'h0000; cnt_down = 1'b1; step();
      chk("R5 copy at zero counting down", lat(4), 16'h00B0);
      cnt_down = 1'b0;
   endtask

   task automatic t_length();
      cnt = 16'h0030;
      wr(2, 16'hABCD);
      len_sel = 2'd1; #1; chk("R2 length code 1", lat(2), 16'h0BCD);
      len_sel = 2'd2; #1; chk("R2 length code 2", lat(2), 16'h03CD);
      len_sel = 2'd3; #1; chk("R2 length code 3", lat(2), 16'h00CD);
      cnt = 16'h12CD; #1;
      chk("R2 masked strobe", {15'd0, cmp_eq[2]}, 16'h0001);
      cnt = 16'h0305;
      wr(1, 16'h0311);
      chk("R2 held at masked nonzero", lat(1), 16'h0055);
      cnt = 16'h0300; step();
      chk("R2 copy at masked zero", lat(1), 16'h0011);
      len_sel = 2'd0; #1;
      chk("R2 full width restored", lat(1), 16'h0311);
   endtask

   task automatic t_pairs();
      grp_sel = 2'd1; set_src(0, 2'd0);
      cnt = 16'h0040;
      wr(0, 16'h1111);
      chk("R9 pair waits for partner", lat(0), 16'h0000);
      wr(1, 16'h2222);
      chk("R8 pair leader immediate ch0", lat(0), 16'h1111);
      chk("R8 pair leader immediate ch1", lat(1), 16'h2222);
   endtask

   task automatic t_halves();
      grp_sel = 2'd2; set_src(5, 2'd0);
      period = 16'h0100; cnt = 16'h0040;
      wr(3, 16'h3333);
      wr(4, 16'h4444);
      cnt = 16'h0100; step();
      chk("R9 partial group no copy", lat(3), 16'h0077);
      cnt = 16'h0040;
      wr(3, 16'h3030);
      wr(5, 16'h5555);
      chk("R8 member policy ignored", lat(5), 16'h0000);
      cnt = 16'h0100; step();
      chk("R9 latest rewrite kept", lat(3), 16'h3030);
      chk("R8 group copy ch4", lat(4), 16'h4444);
      chk("R8 group copy ch5", lat(5), 16'h5555);
   endtask

   task automatic t_all();
      grp_sel = 2'd3; set_src(0, 2'd1);
      cnt = 16'h0040;
      for (int i = 0; i < NCH; i++) wr(i, 16'hA000 + 16'(i));
      chk("R7 all-group held ch0", lat(0), 16'h1111);
      chk("R7 all-group held ch5", lat(5), 16'h5555);
      cnt = 16'h0000; step();
      for (int i = 0; i < NCH; i++) chk("R8 all-group copy", lat(i), 16'hA000 + 16'(i));
      chk("R10 no strobe after copy", {10'd0, cmp_eq}, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_immediate();
      t_zero();
      t_period();
      t_turn();
      t_length();
      t_pairs();
      t_halves();
      t_all();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=timeout exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule